// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block turns the single column address that comes with a READ or WRITE command into the full list of column addresses for the burst that follows. The burst length and beat ordering come from fields the controller has already programmed. Data moves on both clock edges, so the block presents two column addresses per clock: one for the even beat and one for the odd beat. A burst of N beats therefore takes N/2 clocks. Each clock also carries a valid flag and a flag that marks the final pair. One clock after a completed burst, the block raises a one-cycle pulse that permits the row precharge, provided automatic precharge was requested with that command.

The block supports two array organizations. The narrow one has ten column bits. The wide one has an eleventh column bit. On the address pins that bit skips the pin reserved for the precharge flag and lands one position higher. All beat addresses stay inside the burst-aligned block of the start column, so the low bits wrap and the upper bits are unchanged. A new command that arrives while a burst is still running cuts that burst short and starts the new one at once.

Top module: `ddr_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released with no command, `valid_o`, `last_o` and `precharge_go_o` are 0.
- R2: A `start_i` pulse sampled at a rising edge makes `valid_o` high from the next clock for exactly BL/2 clocks, presenting beats 2p and 2p+1 on `beat0_addr_o`/`beat1_addr_o` in clock p, after which `valid_o` returns to 0.
- R3: `bl_code_i` selects the burst length: 2'b01 gives 2, 2'b10 gives 4, 2'b11 gives 8, and the unused code 2'b00 is treated as 2.
- R4: With `interleave_i`=0 (sequential), beat k has low log2(BL) column bits equal to (start + k) mod BL, and all higher column bits equal to those of the start column.
- R5: With `interleave_i`=1, beat k has low log2(BL) column bits equal to start XOR k, and all higher column bits are unchanged.
- R6: `last_o` is 1 only in the final clock of a burst, together with `valid_o`.
- R7: A `start_i` that arrives while a burst is in progress abandons the rest of that burst, and the next clock shows beats 0 and 1 of the new burst.
- R8: `precharge_go_o` pulses for one clock in the clock after a burst's final pair, but only if `auto_pre_i` was 1 at that burst's start. A truncated burst, or one started with `auto_pre_i`=0, gives no pulse.
- R9: With `wide_org_i`=0, column bits 9..0 appear on address bits 9..0, address bits 10 and 11 are 0, and start-column bit 10 is ignored.
- R10: With `wide_org_i`=1, column bit 10 appears on address bit 11, and address bit 10 stays 0.
- R11: The column and all mode inputs are sampled only together with `start_i`. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | READ/WRITE command accepted this clock |
| start_col_i | input | 11 | Start column index (bit 10 used only in wide organization) |
| bl_code_i | input | 2 | Burst length code |
| interleave_i | input | 1 | 0 sequential order, 1 interleaved order |
| wide_org_i | input | 1 | 1 selects the 11-bit column organization |
| auto_pre_i | input | 1 | Precharge automatically after this burst |
| valid_o | output | 1 | Beat addresses valid this clock |
| beat0_addr_o | output | 12 | Even-beat column on address-pin layout |
| beat1_addr_o | output | 12 | Odd-beat column on address-pin layout |
| last_o | output | 1 | Final beat pair of the burst |
| precharge_go_o | output | 1 | Row precharge may begin |

## Verification
The bench uses start columns that sit near the top of an aligned block, so that a design that carries out of the low bits instead of wrapping would disturb the upper column bits. It uses interleaved starts with odd low bits to separate XOR ordering from addition. It drives starts that have column bit 10 set in both organizations: a wrong pin mapping either leaks that bit onto address bit 10 or drops it from bit 11. It cuts bursts short partway through and also restarts exactly on the final pair, which shows whether the precharge pulse wrongly fires for an abandoned burst or is lost for a completed one. Mode inputs are churned between commands, so a design that reads them live instead of latching them would change burst length or order during a burst.

// File: rtl/ddr_colgen_pkg.sv
package ddr_colgen_pkg;

  localparam int MAX_BURST = 8;
  localparam int BEAT_W    = $clog2(MAX_BURST);
  localparam int PAIR_W    = BEAT_W - 1;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic [1:0] bl_code;
    order_e     order;
    logic       wide;
    logic       auto_pre;
  } burst_cfg_t;

  // log2 of the burst length; the unused code behaves as two beats
  function automatic int burst_log2(input logic [1:0] code);
    case (code)
      2'b10:   return 2;
      2'b11:   return 3;
      default: return 1;
    endcase
  endfunction

  // index of the final beat pair of a burst
  function automatic logic [PAIR_W-1:0] final_pair(input logic [1:0] code);
    return PAIR_W'((1 << (burst_log2(code) - 1)) - 1);
  endfunction

endpackage

// File: rtl/ddr_colgen_ctrl.sv
module ddr_colgen_ctrl
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  burst_cfg_t          cfg_i,
  output logic                active_o,
  output logic [PAIR_W-1:0]   pair_o,
  output logic                at_last_o,
  output logic                ap_go_o,
  output logic [COL_W-1:0]    base_col_o,
  output burst_cfg_t          cfg_o
);

  logic               active_q, active_d;
  logic [PAIR_W-1:0]  pair_q, pair_d;
  logic [PAIR_W-1:0]  lastp_q, lastp_d;
  logic [COL_W-1:0]   col_q, col_d;
  burst_cfg_t         cfg_q, cfg_d;
  logic               ap_go_q, ap_go_d;
  logic               at_last;
  logic               load_en;
  logic               step_en;

  assign at_last = active_q && (pair_q == lastp_q);
  assign load_en = start_i;
  assign step_en = active_q && !start_i;

  always_comb begin
    active_d = active_q;
    pair_d   = pair_q;
    lastp_d  = lastp_q;
    col_d    = col_q;
    cfg_d    = cfg_q;
    ap_go_d  = at_last && cfg_q.auto_pre;
    if (load_en) begin
      active_d = 1'b1;
      pair_d   = '0;
      lastp_d  = final_pair(cfg_i.bl_code);
      col_d    = start_col_i;
      cfg_d    = cfg_i;
    end else if (step_en) begin
      if (at_last) begin
        active_d = 1'b0;
      end else begin
        pair_d = pair_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pair_q   <= '0;
      lastp_q  <= '0;
      col_q    <= '0;
      cfg_q    <= '0;
      ap_go_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      pair_q   <= pair_d;
      lastp_q  <= lastp_d;
      col_q    <= col_d;
      cfg_q    <= cfg_d;
      ap_go_q  <= ap_go_d;
    end
  end

  assign active_o   = active_q;
  assign pair_o     = pair_q;
  assign at_last_o  = at_last;
  assign ap_go_o    = ap_go_q;
  assign base_col_o = col_q;
  assign cfg_o      = cfg_q;

  AST_START_LOADS_PAIR0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && pair_q == '0)); // R7

  AST_PAIR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !at_last && !start_i) |=> (active_q && pair_q == PAIR_W'($past(pair_q) + 1'b1))); // R2

  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !start_i) |=> !active_q); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start_i) |=> ($stable(cfg_q) && $stable(col_q))); // R11

endmodule

// File: rtl/ddr_colgen_order.sv
module ddr_colgen_order
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic [COL_W-1:0]  base_col_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [1:0]        bl_code_i,
  input  order_e            order_i,
  output logic [COL_W-1:0]  col_o
);

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] beat_ext;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;
  logic [COL_W-1:0] low_pick;

  always_comb begin
    mask     = COL_W'((1 << burst_log2(bl_code_i)) - 1);
    beat_ext = COL_W'(beat_i);
    seq_col  = base_col_i + beat_ext;
    ilv_col  = base_col_i ^ beat_ext;
    low_pick = (order_i == ORDER_ILV) ? ilv_col : seq_col;
    col_o    = (base_col_i & ~mask) | (low_pick & mask);
  end

endmodule

// File: rtl/ddr_colgen_pinmap.sv
module ddr_colgen_pinmap #(
  parameter int COL_W    = 11,
  parameter int NARROW_W = 10,
  parameter int GAP_BIT  = 10,
  parameter int ADDR_W   = COL_W + 1
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] addr_o
);

  for (genvar a = 0; a < ADDR_W; a++) begin : g_pin
    if (a == GAP_BIT) begin : g_gap
      assign addr_o[a] = 1'b0;
    end else begin : g_col
      localparam int CI = (a < GAP_BIT) ? a : a - 1;
      if (CI >= NARROW_W) begin : g_wide_only
        assign addr_o[a] = col_i[CI] & wide_i;
      end else begin : g_always
        assign addr_o[a] = col_i[CI];
      end
    end
  end

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W    = 11,
  parameter int NARROW_W = 10,
  parameter int GAP_BIT  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             wide_org_i,
  input  logic             auto_pre_i,
  output logic             valid_o,
  output logic [COL_W:0]   beat0_addr_o,
  output logic [COL_W:0]   beat1_addr_o,
  output logic             last_o,
  output logic             precharge_go_o
);

  localparam int ADDR_W = COL_W + 1;
  localparam int LANES  = 2;

  burst_cfg_t        cfg_in;
  burst_cfg_t        cfg_q;
  logic              active;
  logic [PAIR_W-1:0] pair;
  logic              at_last;
  logic              ap_go;
  logic [COL_W-1:0]  base_col;
  logic [COL_W-1:0]  lane_col  [LANES];
  logic [ADDR_W-1:0] lane_addr [LANES];

  always_comb begin
    cfg_in.bl_code  = bl_code_i;
    cfg_in.order    = interleave_i ? ORDER_ILV : ORDER_SEQ;
    cfg_in.wide     = wide_org_i;
    cfg_in.auto_pre = auto_pre_i;
  end

  ddr_colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .cfg_i       (cfg_in),
    .active_o    (active),
    .pair_o      (pair),
    .at_last_o   (at_last),
    .ap_go_o     (ap_go),
    .base_col_o  (base_col),
    .cfg_o       (cfg_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ddr_colgen_order #(.COL_W(COL_W)) u_order (
      .base_col_i (base_col),
      .beat_i     ({pair, l[0]}),
      .bl_code_i  (cfg_q.bl_code),
      .order_i    (cfg_q.order),
      .col_o      (lane_col[l])
    );

    ddr_colgen_pinmap #(
      .COL_W    (COL_W),
      .NARROW_W (NARROW_W),
      .GAP_BIT  (GAP_BIT),
      .ADDR_W   (ADDR_W)
    ) u_pinmap (
      .col_i  (lane_col[l]),
      .wide_i (cfg_q.wide),
      .addr_o (lane_addr[l])
    );
  end

  assign valid_o        = active;
  assign last_o         = at_last;
  assign precharge_go_o = ap_go;
  assign beat0_addr_o   = lane_addr[0];
  assign beat1_addr_o   = lane_addr[1];

  AST_LANES_SAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (lane_col[0][COL_W-1:BEAT_W] == lane_col[1][COL_W-1:BEAT_W])); // R4

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i) |=> (!valid_o || $stable(lane_col[0][COL_W-1:BEAT_W]))); // R4

endmodule

// File: tb/tb_ddr_burst_colgen.sv
`timescale 1ns/1ps
module tb_ddr_burst_colgen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [10:0] start_col_i;
  logic [1:0]  bl_code_i;
  logic        interleave_i;
  logic        wide_org_i;
  logic        auto_pre_i;
  logic        valid_o;
  logic [11:0] beat0_addr_o;
  logic [11:0] beat1_addr_o;
  logic        last_o;
  logic        precharge_go_o;

  always #2.5 clk = ~clk;

  ddr_burst_colgen dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .start_col_i    (start_col_i),
    .bl_code_i      (bl_code_i),
    .interleave_i   (interleave_i),
    .wide_org_i     (wide_org_i),
    .auto_pre_i     (auto_pre_i),
    .valid_o        (valid_o),
    .beat0_addr_o   (beat0_addr_o),
    .beat1_addr_o   (beat1_addr_o),
    .last_o         (last_o),
    .precharge_go_o (precharge_go_o)
  );

  typedef struct {
    logic [11:0] a0;
    logic [11:0] a1;
    bit          last;
    bit          ap;
  } pair_t;

  pair_t  expq[$];
  bit     ap_pend = 1'b0;
  int     checks  = 0;
  int     fails   = 0;
  int     cycles  = 0;
  int     junk    = 7;
  string  req     = "R1";

  function automatic int bl_of(input logic [1:0] code);
    return (code == 2'b11) ? 8 : (code == 2'b10) ? 4 : 2;
  endfunction

  function automatic logic [11:0] exp_addr(input logic [10:0] s, input int k,
                                           input int bl, input bit il, input bit wide);
    int lo;
    logic [10:0] c;
    lo = il ? ((int'(s) & (bl - 1)) ^ k) : (((int'(s) & (bl - 1)) + k) % bl);
    c  = (s & ~11'(bl - 1)) | 11'(lo);
    return {wide ? c[10] : 1'b0, 1'b0, c[9:0]};
  endfunction

  task automatic check1(input string what, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_now();
    pair_t e;
    bit    exp_v;
    exp_v = (expq.size() > 0);
    check1("valid", {11'd0, valid_o}, {11'd0, exp_v});
    check1("precharge_go", {11'd0, precharge_go_o}, {11'd0, ap_pend});
    if (exp_v) begin
      e = expq.pop_front();
      check1("beat0_addr", beat0_addr_o, e.a0);
      check1("beat1_addr", beat1_addr_o, e.a1);
      check1("last", {11'd0, last_o}, {11'd0, e.last});
      ap_pend = e.last && e.ap;
    end else begin
      check1("last", {11'd0, last_o}, 12'd0);
      ap_pend = 1'b0;
    end
  endtask

  // one clock: compare at the falling edge, then drive for the next rising edge
  task automatic tick(input bit st, input logic [10:0] col, input logic [1:0] code,
                      input bit il, input bit wide, input bit ap);
    pair_t e;
    int    bl;
    @(negedge clk);
    compare_now();
    start_i      = st;
    start_col_i  = col;
    bl_code_i    = code;
    interleave_i = il;
    wide_org_i   = wide;
    auto_pre_i   = ap;
    if (st) begin
      expq.delete();
      bl = bl_of(code);
      for (int p = 0; p < bl / 2; p++) begin
        e.a0   = exp_addr(col, 2 * p, bl, il, wide);
        e.a1   = exp_addr(col, 2 * p + 1, bl, il, wide);
        e.last = (p == bl / 2 - 1);
        e.ap   = ap;
        expq.push_back(e);
      end
    end
  endtask

  // idle clocks with churning mode inputs (R11)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      junk = (junk * 37 + 11) % 2048;
      tick(1'b0, 11'(junk), 2'(junk), junk[2], junk[3], junk[4]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0; start_col_i = '0; bl_code_i = 2'b11;
    interleave_i = 1'b0; wide_org_i = 1'b0; auto_pre_i = 1'b0;
    req = "R1";
    @(negedge clk); compare_now();
    @(negedge clk); compare_now();
    rst_n = 1'b1;
    idle(3);

    req = "R2 R4 R6 R8";                 // sequential BL8 near block top, precharge on
    tick(1'b1, 11'h005, 2'b11, 1'b0, 1'b0, 1'b1);
    idle(6);

    req = "R5";                          // interleaved BL8, odd low bits
    tick(1'b1, 11'h3FD, 2'b11, 1'b1, 1'b0, 1'b0);
    idle(5);

    req = "R10";                         // wide organization, column bit 10 set
    tick(1'b1, 11'h7F6, 2'b10, 1'b0, 1'b1, 1'b0);
    idle(3);
    req = "R9";                          // narrow organization ignores column bit 10
    tick(1'b1, 11'h7F7, 2'b10, 1'b1, 1'b0, 1'b1);
    idle(3);

    req = "R3";                          // unused code behaves as BL2, then BL2 and BL4
    tick(1'b1, 11'h003, 2'b00, 1'b0, 1'b0, 1'b1);
    idle(2);
    tick(1'b1, 11'h12B, 2'b01, 1'b1, 1'b1, 1'b0);
    idle(2);
    tick(1'b1, 11'h40E, 2'b10, 1'b0, 1'b1, 1'b1);
    idle(3);

    req = "R7 R8";                       // truncated burst gives no precharge pulse
    tick(1'b1, 11'h0A6, 2'b11, 1'b0, 1'b0, 1'b1);
    idle(1);
    tick(1'b1, 11'h2C1, 2'b10, 1'b1, 1'b1, 1'b0);
    idle(4);

    req = "R7 R8 restart-on-last";       // restart in final pair keeps the pulse
    tick(1'b1, 11'h053, 2'b10, 1'b0, 1'b0, 1'b1);
    idle(1);
    tick(1'b1, 11'h1E7, 2'b11, 1'b1, 1'b0, 1'b1);
    idle(6);

    req = "R11";                         // fields churn during a long burst
    tick(1'b1, 11'h6CB, 2'b11, 1'b1, 1'b1, 1'b0);
    idle(6);

    req = "R2 R4 R5 R9 R10 sweep";
    for (int i = 0; i < 60; i++) begin
      junk = (junk * 53 + 29) % 2048;
      tick(1'b1, 11'(junk), 2'(i), junk[1], junk[6], junk[3]);
      idle(i % 5);
    end
    idle(6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule